// File: doc/BRIEF.md
# Base Address Region Decoder

This block turns the raw contents of a function's base address registers into a live address map. There are up to six ordinary regions and one expansion ROM region. For every region it decides, from the command enables and the raw register value, whether the region is currently mapped and at which aligned base. Each region's size (a power of two), its kind (IO or memory) and whether it exists at all are fixed by parameters. The ROM region is always the last index and always decodes as memory.

A requester presents an address and an IO/memory qualifier. The block answers combinationally with a one-hot vector naming the single region that claims the access. Where regions overlap, the lower index takes the access. A small two-state tracker, with states STEADY and NOTIFY, watches the computed map. The transition STEADY→NOTIFY is taken on any cycle in which some region's valid flag or base differs from the value recorded at the previous clock edge. The transition NOTIFY→NOTIFY is taken when the map differs again. The transition NOTIFY→STEADY is taken when the map is unchanged. `change_pulse` is high exactly while the tracker is in NOTIFY, so that logic downstream can rebuild its routing.

Top module: `bard_top`

## Requirements
- R1: A region of IO kind can be valid only while `cmd_io_en` is 1. A memory region or the ROM region can be valid only while `cmd_mem_en` is 1. A region whose present bit is 0 is never valid.
- R2: The effective base of region i is its 32-bit raw word (bits [32*i+31:32*i] of `bar_raw`) ANDed with ~(size−1), and its end is base + size − 1. A valid region reports that base on bits [32*i+31:32*i] of `region_base`. An invalid region reports `region_valid[i]`=0 and a base of 0.
- R3: A region whose effective base is zero is invalid, and so is a region whose end is not above its base.
- R4: A memory or ROM region whose end equals 0xFFFFFFFF is invalid.
- R5: An IO region whose end is 0x10000 or above is invalid. With the default IO space of 16 address bits, an end of 0xFFFF is still allowed.
- R6: The ROM region (index `NUM_BARS`) is valid only when bit 0 of its raw word is 1. That bit lies below the size mask, so it never appears in the base.
- R7: `hit_onehot[i]` can be 1 only when region i is valid, `acc_is_io` equals the region's kind (1 = IO), and `acc_addr` ANDed with ~(size−1) equals its base. The result is combinational, in the same cycle as the address.
- R8: When several regions match, only the lowest index is reported. `hit_onehot` is zero or one-hot, and `hit_any` is its OR.
- R9: When the computed map, meaning any valid flag or any reported base, differs from its value at the previous clock edge, `change_pulse` is 1 for the cycle after the next clock edge. When the map is unchanged, `change_pulse` is 0. After reset the recorded map is all-invalid.
- R10: A change of raw words, or of the enables, that leaves every region's valid flag and base unchanged produces no `change_pulse`.
- R11: While `rst_n` is 0, the tracker is held in STEADY and `change_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_io_en | input | 1 | Command-register IO decode enable |
| cmd_mem_en | input | 1 | Command-register memory decode enable |
| bar_raw | input | (NUM_BARS+1)*32 | Raw register words; region i at bits [32*i+31:32*i], ROM last |
| acc_addr | input | 32 | Address of the access to decode |
| acc_is_io | input | 1 | 1 for an IO access, 0 for a memory access |
| region_valid | output | NUM_BARS+1 | Per-region mapped flag |
| region_base | output | (NUM_BARS+1)*32 | Per-region effective base, 0 when not mapped |
| hit_onehot | output | NUM_BARS+1 | Winning region for the access |
| hit_any | output | 1 | Some region claims the access |
| change_pulse | output | 1 | One-cycle notice that the map changed |

## Verification
Address decode and change tracking can act on the same cycle: a raw word or an enable moves a region while an access aimed at the new base is being decoded. The bench provokes this in most random steps. It writes new raw words and, before the next edge, probes addresses derived from the map it expects after the write. Each hit is judged against the new map in that same cycle. The pulse is judged one edge later against whether the bench's expected map differs from the previous step's map.

// File: rtl/bard_pkg.sv
package bard_pkg;

    localparam int ADDR_W = 32;

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] base;
    } map_t;

    typedef enum logic {
        TRK_STEADY = 1'b0,
        TRK_NOTIFY = 1'b1
    } trk_state_e;

    function automatic logic [ADDR_W-1:0] span_m1(input int unsigned lg);
        return (ADDR_W'(1) << lg) - ADDR_W'(1);
    endfunction

endpackage

// File: rtl/bard_region.sv
module bard_region
    import bard_pkg::*;
#(
    parameter bit          PRESENT       = 1'b1,
    parameter bit          IS_IO         = 1'b0,
    parameter bit          IS_ROM        = 1'b0,
    parameter int unsigned SIZE_LOG2     = 12,
    parameter int unsigned IO_SPACE_LOG2 = 16
) (
    input  logic              io_en,
    input  logic              mem_en,
    input  logic [ADDR_W-1:0] raw,
    output map_t              map
);
    localparam logic [ADDR_W-1:0] SPAN_M1 = span_m1(SIZE_LOG2);
    localparam logic [ADDR_W-1:0] IO_TOP  = span_m1(IO_SPACE_LOG2);

    logic [ADDR_W-1:0] aligned;
    logic [ADDR_W-1:0] last;
    logic              enabled;
    logic              range_ok;
    logic              space_ok;

    assign aligned = raw & ~SPAN_M1;
    assign last    = aligned + SPAN_M1;
    assign enabled = IS_IO ? io_en : (mem_en && (!IS_ROM || raw[0]));
    assign range_ok = (aligned != '0) && (last > aligned);
    assign space_ok = IS_IO ? (last <= IO_TOP) : (last != '1);

    always_comb begin
        map.valid = PRESENT && enabled && range_ok && space_ok;
        map.base  = map.valid ? aligned : '0;
    end
endmodule

// File: rtl/bard_match.sv
module bard_match
    import bard_pkg::*;
#(
    parameter int                     NREG          = 7,
    parameter logic [NREG-1:0]        REG_IS_IO     = '0,
    parameter logic [NREG*5-1:0]      REG_SIZE_LOG2 = '0
) (
    input  map_t [NREG-1:0]   maps,
    input  logic [ADDR_W-1:0] addr,
    input  logic              is_io,
    output logic [NREG-1:0]   hit,
    output logic              any
);
    logic [NREG-1:0] cand;

    for (genvar i = 0; i < NREG; i++) begin : g_cmp
        localparam logic [ADDR_W-1:0] MASK = ~span_m1(REG_SIZE_LOG2[5*i +: 5]);
        assign cand[i] = maps[i].valid && (is_io == REG_IS_IO[i])
                         && ((addr & MASK) == maps[i].base);
    end

    always_comb begin
        logic taken;
        taken = 1'b0;
        hit   = '0;
        for (int i = 0; i < NREG; i++) begin
            if (cand[i] && !taken) begin
                hit[i] = 1'b1;
                taken  = 1'b1;
            end
        end
    end

    assign any = |hit;
endmodule

// File: rtl/bard_track.sv
module bard_track
    import bard_pkg::*;
#(
    parameter int NREG = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  map_t [NREG-1:0] maps,
    output logic            pulse
);
    map_t [NREG-1:0] seen;
    trk_state_e      state, state_nx;
    logic            moved;

    assign moved = (maps != seen);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seen <= '0;
        else        seen <= maps;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= TRK_STEADY;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            TRK_STEADY: if (moved)  state_nx = TRK_NOTIFY;
            TRK_NOTIFY: if (!moved) state_nx = TRK_STEADY;
            default:                state_nx = TRK_STEADY;
        endcase
    end

    always_comb begin
        pulse = 1'b0;
        unique case (state)
            TRK_STEADY: pulse = 1'b0;
            TRK_NOTIFY: pulse = 1'b1;
            default:    pulse = 1'b0;
        endcase
    end
endmodule

// File: rtl/bard_top.sv
module bard_top
    import bard_pkg::*;
#(
    parameter int                       NUM_BARS      = 6,
    parameter int unsigned              IO_SPACE_LOG2 = 16,
    parameter logic [NUM_BARS:0]        REG_PRESENT   = 7'b1011111,
    parameter logic [NUM_BARS:0]        REG_IS_IO     = 7'b0001010,
    parameter logic [(NUM_BARS+1)*5-1:0] REG_SIZE_LOG2 =
        {5'd16, 5'd0, 5'd12, 5'd8, 5'd16, 5'd5, 5'd12}
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cmd_io_en,
    input  logic                         cmd_mem_en,
    input  logic [(NUM_BARS+1)*32-1:0]   bar_raw,
    input  logic [31:0]                  acc_addr,
    input  logic                         acc_is_io,
    output logic [NUM_BARS:0]            region_valid,
    output logic [(NUM_BARS+1)*32-1:0]   region_base,
    output logic [NUM_BARS:0]            hit_onehot,
    output logic                         hit_any,
    output logic                         change_pulse
);
    localparam int NREG    = NUM_BARS + 1;
    localparam int ROM_IDX = NUM_BARS;

    map_t [NREG-1:0] maps;

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        bard_region #(
            .PRESENT      (REG_PRESENT[i]),
            .IS_IO        ((i != ROM_IDX) && REG_IS_IO[i]),
            .IS_ROM       (i == ROM_IDX),
            .SIZE_LOG2    (REG_SIZE_LOG2[5*i +: 5]),
            .IO_SPACE_LOG2(IO_SPACE_LOG2)
        ) u_region (
            .io_en (cmd_io_en),
            .mem_en(cmd_mem_en),
            .raw   (bar_raw[32*i +: 32]),
            .map   (maps[i])
        );
        assign region_valid[i]       = maps[i].valid;
        assign region_base[32*i +: 32] = maps[i].base;
    end

    bard_match #(
        .NREG         (NREG),
        .REG_IS_IO    (REG_IS_IO & ~(NREG'(1) << ROM_IDX)),
        .REG_SIZE_LOG2(REG_SIZE_LOG2)
    ) u_match (
        .maps (maps),
        .addr (acc_addr),
        .is_io(acc_is_io),
        .hit  (hit_onehot),
        .any  (hit_any)
    );

    bard_track #(.NREG(NREG)) u_track (
        .clk  (clk),
        .rst_n(rst_n),
        .maps (maps),
        .pulse(change_pulse)
    );
endmodule

// File: rtl/bard_checker.sv
module bard_checker #(
    parameter int              NREG      = 7,
    parameter logic [NREG-1:0] KIND_IO   = '0
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_io_en,
    input logic                 cmd_mem_en,
    input logic [NREG-1:0]      region_valid,
    input logic [NREG*32-1:0]   region_base,
    input logic [NREG-1:0]      hit_onehot,
    input logic                 hit_any,
    input logic                 change_pulse
);
    logic primed;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) primed <= 1'b0;
        else        primed <= 1'b1;
    end

    a_r8_hit_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit_onehot));

    a_r8_any_matches: assert property (@(posedge clk) disable iff (!rst_n)
        hit_any == (hit_onehot != '0));

    a_r7_hit_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_onehot & ~region_valid) == '0);

    a_r9_pulse_follows_change: assert property (@(posedge clk)
        disable iff (!rst_n || !primed)
        !$stable({region_valid, region_base}) |=> change_pulse);

    a_r11_quiet_in_reset: assert property (@(posedge clk)
        !rst_n |-> !change_pulse);

    for (genvar i = 0; i < NREG; i++) begin : g_chk
        a_r1_enable_gate: assert property (@(posedge clk) disable iff (!rst_n)
            region_valid[i] |-> (KIND_IO[i] ? cmd_io_en : cmd_mem_en));
        a_r3_nonzero_base: assert property (@(posedge clk) disable iff (!rst_n)
            region_valid[i] |-> (region_base[32*i +: 32] != 32'h0));
        a_r2_invalid_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !region_valid[i] |-> (region_base[32*i +: 32] == 32'h0));
    end
endmodule

bind bard_top bard_checker #(
    .NREG   (NUM_BARS + 1),
    .KIND_IO(REG_IS_IO & ~((NUM_BARS + 1)'(1) << NUM_BARS))
) u_bard_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_io_en   (cmd_io_en),
    .cmd_mem_en  (cmd_mem_en),
    .region_valid(region_valid),
    .region_base (region_base),
    .hit_onehot  (hit_onehot),
    .hit_any     (hit_any),
    .change_pulse(change_pulse)
);

// File: tb/tb_bard_top.sv
`timescale 1ns/1ps
module tb_bard_top;
    localparam int NR = 7;
    localparam logic [NR-1:0] PRES = 7'b1011111;
    localparam logic [NR-1:0] KIO  = 7'b0001010;
    localparam int LG [NR] = '{12, 5, 16, 8, 12, 0, 16};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic io_en = 1'b0, mem_en = 1'b0;
    logic [NR*32-1:0] raw_flat = '0;
    logic [31:0] addr = '0;
    logic is_io = 1'b0;
    logic [NR-1:0] v_out, hit;
    logic [NR*32-1:0] b_out;
    logic any, pulse;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [31:0] bars [NR];
    logic        pv [NR];
    logic [31:0] pb [NR];

    always #10 clk = ~clk;

    bard_top dut (
        .clk(clk), .rst_n(rst_n), .cmd_io_en(io_en), .cmd_mem_en(mem_en),
        .bar_raw(raw_flat), .acc_addr(addr), .acc_is_io(is_io),
        .region_valid(v_out), .region_base(b_out), .hit_onehot(hit),
        .hit_any(any), .change_pulse(pulse)
    );

    function automatic logic [31:0] m1(input int i);
        return (32'd1 << LG[i]) - 32'd1;
    endfunction

    function automatic logic [32:0] expect_map(input int i);
        logic [31:0] bs, en;
        logic ok;
        bs = bars[i] & ~m1(i);
        en = bs + m1(i);
        ok = PRES[i] && (KIO[i] ? io_en : mem_en) && bs != 0 && en > bs;
        if (KIO[i]) ok = ok && (en < 32'h0001_0000);   // R5
        else        ok = ok && (en != 32'hFFFF_FFFF);  // R4
        if (i == NR - 1) ok = ok && bars[i][0];        // R6
        return {ok, ok ? bs : 32'h0};
    endfunction

    function automatic logic [NR-1:0] expect_hit(input logic [31:0] a, input logic io);
        logic [32:0] m;
        for (int i = 0; i < NR; i++) begin
            m = expect_map(i);
            if (m[32] && (KIO[i] == io) && ((a & ~m1(i)) == m[31:0]))
                return NR'(1) << i;
        end
        return '0;
    endfunction

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic probe(input logic [31:0] a, input logic io);
        logic [NR-1:0] e;
        addr = a; is_io = io;
        #1;
        e = expect_hit(a, io);
        // R7 R8
        check(hit == e && any == (e != 0), "R7/R8 hit", {hit, any}, {e, (e != 0)});
    endtask

    // Drive at negedge, check map and hits, then check the pulse after the edge.
    task automatic step(input int nprobe);
        logic [32:0] m;
        bit moved;
        for (int i = 0; i < NR; i++) raw_flat[32*i +: 32] = bars[i];
        #1;
        moved = 0;
        for (int i = 0; i < NR; i++) begin
            m = expect_map(i);
            // R1 R2 R3
            check(v_out[i] == m[32] && b_out[32*i +: 32] == m[31:0],
                  $sformatf("R1/R2/R3 region %0d", i),
                  {31'h0, v_out[i], b_out[32*i +: 32]}, {31'h0, m});
            if (m[32] != pv[i] || m[31:0] != pb[i]) moved = 1;
            pv[i] = m[32]; pb[i] = m[31:0];
        end
        for (int j = 0; j < nprobe; j++) begin
            int r;
            logic [32:0] mm;
            r = int'($urandom % NR);
            mm = expect_map(r);
            if (j == nprobe - 1) probe($urandom, 1'($urandom));
            else probe((mm[32] ? mm[31:0] : (bars[r] & ~m1(r))) | ($urandom & m1(r)),
                       ($urandom % 4 == 0) ? ~KIO[r] : KIO[r]);
        end
        @(negedge clk);
        // R9 R10
        check(pulse == moved, "R9/R10 change pulse", {63'h0, pulse}, {63'h0, moved});
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL R9 watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < NR; i++) begin bars[i] = '0; pv[i] = 0; pb[i] = '0; end
        repeat (3) @(negedge clk);
        // R11: quiet while in reset
        check(pulse == 0 && v_out == 0, "R11 reset state", {pulse, v_out}, '0);
        rst_n = 1'b1;
        @(negedge clk);
        check(pulse == 0, "R11 after release", {63'h0, pulse}, '0);

        // R1: IO enabled only, memory regions stay invalid
        io_en = 1; mem_en = 0;
        bars[0] = 32'h0000_2000; bars[1] = 32'h0000_0C20; bars[3] = 32'h0000_0400;
        bars[6] = 32'h0004_0001;
        step(3);
        // R1: memory enabled, IO off
        io_en = 0; mem_en = 1;
        step(3);
        // R10: raw change of an absent region and bits under the mask only
        bars[5] = 32'hDEAD_BEEF; bars[0] = 32'h0000_2ABC;
        step(1);
        // R3: zero base
        bars[2] = 32'h0000_FFFF;
        step(1);
        // R4: memory region ending at the top of the space
        bars[0] = 32'hFFFF_F000;
        step(1);
        // R5: IO end 0xFFFF allowed, 0x10000 not
        io_en = 1;
        bars[1] = 32'h0000_FFE0;
        step(2);
        bars[1] = 32'h0001_0000;
        step(1);
        // R6: ROM enable bit off, then on
        bars[6] = 32'h0002_0000;
        step(1);
        bars[6] = 32'h0002_0001;
        step(2);
        // R8: two overlapping memory regions, lowest index wins
        bars[0] = 32'h0003_1000; bars[4] = 32'h0003_1000;
        step(1);
        probe(32'h0003_1044, 1'b0);
        @(negedge clk);
        // R10: enables toggle while nothing can map
        for (int i = 0; i < NR; i++) bars[i] = '0;
        step(1);
        io_en = 0; mem_en = 0;
        step(1);

        for (int n = 0; n < 400; n++) begin
            io_en  = ($urandom % 4) != 0;
            mem_en = ($urandom % 4) != 0;
            for (int i = 0; i < NR; i++) begin
                case ($urandom % 7)
                    0: bars[i] = 32'h0;
                    1: bars[i] = $urandom;
                    2: bars[i] = 32'hFFFF_0000 | ($urandom & 32'hFFFF);
                    3: bars[i] = $urandom & 32'h0000_FFFF;
                    4: bars[i] = 32'h0001_0000 | ($urandom & 32'h0003_FFFF);
                    5: if (i == 4) bars[i] = bars[0];
                    default: ;
                endcase
            end
            step(4);
        end

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule